// File: doc/BRIEF.md
# Masked Lane-Wise Vector XOR Unit

This unit is one execution slice of a 512-bit vector datapath. It takes two source vectors made of packed 64-bit elements and XORs them element by element. The result is written into a full 512-bit destination image. The elements are handled as raw bit patterns. Floating-point encodings such as NaN or denormal values pass through untouched, and no exception flag exists or is raised.

Control inputs set four things:

- how many lanes take part, chosen by the vector length;
- which of those lanes are written, chosen by a per-lane mask;
- what a lane that is not written holds, either the old destination lane (merge) or zero;
- whether the second operand is a single 64-bit value repeated across all lanes.

An encoding-class input picks between two forms. The extended form clears everything above the vector length. The legacy 128-bit form uses the first source as the destination and keeps its upper bits.

The result is captured one cycle after an input strobe and is shown with a one-cycle valid pulse.

Top module: `vxor_lane_unit`

## Requirements
- R1: For the extended form (`enc_ext`=1), lane j is bits [64j+63:64j]. When `mask_en`=0 or `lane_mask[j]`=1, an in-length lane j becomes `src_a` lane j XOR the second operand lane. Bit patterns pass through unaltered.
- R2: The vector length code `vlen` sets the in-length lane count: 00 gives 2 lanes, 01 gives 4 lanes, and 10 or 11 give 8 lanes.
- R3: With `enc_ext`=1, `bcast`=1 and `b_is_mem`=1, every written lane XORs with `src_b[63:0]`.
- R4: With `b_is_mem`=0, `bcast` has no effect, and each lane uses its own `src_b` lane.
- R5: With `enc_ext`=1, `mask_en`=1, `lane_mask[j]`=0 and `zero_mode`=0, in-length lane j takes `old_dst` lane j.
- R6: With `enc_ext`=1, `mask_en`=1, `lane_mask[j]`=0 and `zero_mode`=1, in-length lane j becomes zero.
- R7: With `enc_ext`=1, every bit from the vector length up to bit 511 is zero. Mask bits of lanes at or above the lane count have no effect.
- R8: With `enc_ext`=0, bits [127:0] are `src_a[127:0]` XOR `src_b[127:0]`, and bits [511:128] equal `src_a[511:128]`. In this form `vlen`, `lane_mask`, `mask_en`, `zero_mode`, `bcast`, `b_is_mem` and `old_dst` have no effect.
- R9: Each cycle with `in_valid`=1 sets `out_valid` high on the next cycle, with `result` holding that operation. A cycle with `in_valid`=0 gives `out_valid`=0 on the next cycle and leaves `result` unchanged.
- R10: While `rst_n` is low, `out_valid` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| src_a | input | 512 | First source; also the destination image in the legacy form |
| src_b | input | 512 | Second source vector or memory operand |
| old_dst | input | 512 | Prior destination contents, used by merge masking |
| vlen | input | 2 | Vector length code (00=128, 01=256, 1x=512) |
| lane_mask | input | 8 | Per-lane write mask |
| mask_en | input | 1 | 1 when the mask is applied |
| zero_mode | input | 1 | 1 zeroes unwritten lanes, 0 merges them |
| bcast | input | 1 | Repeat the low 64 bits of the second operand |
| b_is_mem | input | 1 | Second operand comes from memory |
| enc_ext | input | 1 | 1 selects the extended form, 0 the legacy 128-bit form |
| out_valid | output | 1 | One-cycle result strobe |
| result | output | 512 | Registered destination image |

## Verification
The hardest case to reach is the meeting of three controls on one lane. A mask bit for a lane beyond the vector length must be ignored, while broadcast and merge or zero policy still act on the lanes inside the length. Reaching this needs mask patterns that differ only above the lane count.

The bench therefore sweeps all 256 mask values against every vector length code, both encodings and all 16 combinations of mask enable, zero mode, broadcast and memory flag. Each operation gets fresh operands. Idle cycles with changed inputs are mixed in to show that the result holds.

// File: rtl/vxor_pkg.sv
`timescale 1ns/1ps
package vxor_pkg;
  // Vector length codes
  localparam logic [1:0] VL_SHORT = 2'b00;
  localparam logic [1:0] VL_MID   = 2'b01;

  // Lane count for a length code: base count doubled per step, clamped.
  function automatic int unsigned span_lanes(input logic [1:0] vl,
                                             input int unsigned base,
                                             input int unsigned limit);
    int unsigned n;
    n = base << vl;
    if (n > limit) n = limit;
    return n;
  endfunction
endpackage

// File: rtl/vxor_lane_sel.sv
`timescale 1ns/1ps
module vxor_lane_sel import vxor_pkg::*; #(
  parameter int LANES        = 8,
  parameter int LEGACY_LANES = 2
) (
  input  logic [1:0]       vlen,
  input  logic [LANES-1:0] lane_mask,
  input  logic             mask_en,
  input  logic             enc_ext,
  output logic [LANES-1:0] in_len,
  output logic [LANES-1:0] write_en
);
  int unsigned ext_count;

  always_comb ext_count = span_lanes(vlen, LEGACY_LANES, LANES);

  for (genvar j = 0; j < LANES; j++) begin : g_sel
    always_comb begin
      if (enc_ext) in_len[j] = (32'(j) < ext_count);
      else         in_len[j] = (j < LEGACY_LANES);
      write_en[j] = in_len[j] & (~enc_ext | ~mask_en | lane_mask[j]);
    end
  end
endmodule

// File: rtl/vxor_lane.sv
`timescale 1ns/1ps
module vxor_lane #(
  parameter int ELEM_W = 64
) (
  input  logic [ELEM_W-1:0] a,
  input  logic [ELEM_W-1:0] b_own,
  input  logic [ELEM_W-1:0] b_scalar,
  input  logic [ELEM_W-1:0] old,
  input  logic              use_scalar,
  input  logic              in_len,
  input  logic              write_en,
  input  logic              zero_mode,
  input  logic              legacy,
  output logic [ELEM_W-1:0] y
);
  function automatic logic [ELEM_W-1:0] lane_pick(
      input logic [ELEM_W-1:0] fa, input logic [ELEM_W-1:0] fb,
      input logic [ELEM_W-1:0] fold, input logic fin, input logic fwr,
      input logic fzero, input logic fleg);
    if (!fin)      return fleg ? fa : '0;
    else if (fwr)  return fa ^ fb;
    else if (fzero) return '0;
    else           return fold;
  endfunction

  logic [ELEM_W-1:0] b_sel;
  always_comb b_sel = use_scalar ? b_scalar : b_own;
  always_comb y = lane_pick(a, b_sel, old, in_len, write_en, zero_mode, legacy);
endmodule

// File: rtl/vxor_lane_unit.sv
`timescale 1ns/1ps
module vxor_lane_unit import vxor_pkg::*; #(
  parameter int ELEM_W       = 64,
  parameter int LANES        = 8,
  parameter int LEGACY_LANES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [ELEM_W*LANES-1:0] src_a,
  input  logic [ELEM_W*LANES-1:0] src_b,
  input  logic [ELEM_W*LANES-1:0] old_dst,
  input  logic [1:0]              vlen,
  input  logic [LANES-1:0]        lane_mask,
  input  logic                    mask_en,
  input  logic                    zero_mode,
  input  logic                    bcast,
  input  logic                    b_is_mem,
  input  logic                    enc_ext,
  output logic                    out_valid,
  output logic [ELEM_W*LANES-1:0] result
);
  localparam int VEC_W = ELEM_W * LANES;
  localparam int LEG_W = ELEM_W * LEGACY_LANES;

  logic             use_scalar;
  logic [LANES-1:0] in_len;
  logic [LANES-1:0] write_en;
  logic [VEC_W-1:0] next_result;

  always_comb use_scalar = enc_ext & bcast & b_is_mem;

  vxor_lane_sel #(.LANES(LANES), .LEGACY_LANES(LEGACY_LANES)) u_sel (
    .vlen(vlen), .lane_mask(lane_mask), .mask_en(mask_en), .enc_ext(enc_ext),
    .in_len(in_len), .write_en(write_en)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    vxor_lane #(.ELEM_W(ELEM_W)) u_lane (
      .a(src_a[j*ELEM_W +: ELEM_W]),
      .b_own(src_b[j*ELEM_W +: ELEM_W]),
      .b_scalar(src_b[ELEM_W-1:0]),
      .old(old_dst[j*ELEM_W +: ELEM_W]),
      .use_scalar(use_scalar),
      .in_len(in_len[j]),
      .write_en(write_en[j]),
      .zero_mode(zero_mode),
      .legacy(~enc_ext),
      .y(next_result[j*ELEM_W +: ELEM_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_result;
    end
  end

  // R9
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));
  // R7
  ext_upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enc_ext && vlen == VL_SHORT) |=> (result[VEC_W-1:LEG_W] == '0));
  // R8
  legacy_upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !enc_ext) |=> (result[VEC_W-1:LEG_W] == $past(src_a[VEC_W-1:LEG_W])));
  // R6
  zero_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enc_ext && mask_en && zero_mode && !lane_mask[0])
      |=> (result[ELEM_W-1:0] == '0));
  // R10
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && result == '0));
endmodule

// File: tb/tb_vxor_lane_unit.sv
`timescale 1ns/1ps
module tb_vxor_lane_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [511:0] src_a = '0, src_b = '0, old_dst = '0;
  logic [1:0] vlen = '0;
  logic [7:0] lane_mask = '0;
  logic mask_en = 0, zero_mode = 0, bcast = 0, b_is_mem = 0, enc_ext = 0;
  logic out_valid;
  logic [511:0] result;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  logic [511:0] last_exp = '0;

  always #10 clk = ~clk;

  vxor_lane_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .old_dst(old_dst), .vlen(vlen), .lane_mask(lane_mask), .mask_en(mask_en),
    .zero_mode(zero_mode), .bcast(bcast), .b_is_mem(b_is_mem), .enc_ext(enc_ext),
    .out_valid(out_valid), .result(result)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual cycles=%0d expected below 150000", cycles);
      finish_run();
    end
  end

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  // Independent reference of the requirement text
  function automatic logic [511:0] model(
      input logic [511:0] a, input logic [511:0] b, input logic [511:0] od,
      input logic [1:0] vl, input logic [7:0] m, input logic men, input logic z,
      input logic bc, input logic mem, input logic ext);
    logic [511:0] r;
    int n;
    if (!ext) begin
      r = a;
      r[127:0] = a[127:0] ^ b[127:0];
      return r;
    end
    n = (vl == 2'b00) ? 2 : (vl == 2'b01) ? 4 : 8;
    r = '0;
    for (int k = 0; k < n; k++) begin
      if (!men || m[k])
        r[64*k +: 64] = a[64*k +: 64] ^ ((bc && mem) ? b[63:0] : b[64*k +: 64]);
      else if (!z)
        r[64*k +: 64] = od[64*k +: 64];
    end
    return r;
  endfunction

  function automatic string lane_tag(input int k);
    int n;
    if (!enc_ext) return (k < 2) ? "R1" : "R8";
    n = (vlen == 2'b00) ? 2 : (vlen == 2'b01) ? 4 : 8;
    if (k >= n) return "R7";
    if (mask_en && !lane_mask[k]) return zero_mode ? "R6" : "R5";
    if (bcast) return b_is_mem ? "R3" : "R4";
    return (k >= 2) ? "R2" : "R1";
  endfunction

  task automatic check_result(input logic [511:0] exp);
    checks++;
    if (result !== exp) begin
      errors++;
      for (int k = 0; k < 8; k++)
        if (result[64*k +: 64] !== exp[64*k +: 64]) begin
          $display("FAIL %s lane %0d: actual %h expected %h", lane_tag(k), k,
                   result[64*k +: 64], exp[64*k +: 64]);
          break;
        end
    end
  endtask

  task automatic run_op();
    logic [511:0] exp;
    exp = model(src_a, src_b, old_dst, vlen, lane_mask, mask_en, zero_mode,
                bcast, b_is_mem, enc_ext);
    in_valid = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b1) begin
      errors++;
      $display("FAIL R9 out_valid: actual %b expected 1", out_valid);
    end
    check_result(exp);
    last_exp = exp;
    in_valid = 1'b0;
  endtask

  task automatic idle_check();
    in_valid = 1'b0;
    src_a = rnd512(); src_b = rnd512(); old_dst = rnd512();
    lane_mask = 8'($urandom); enc_ext = ~enc_ext;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R9 idle out_valid: actual %b expected 0", out_valid);
    end
    checks++;
    if (result !== last_exp) begin
      errors++;
      $display("FAIL R9 idle hold: actual %h expected %h", result, last_exp);
    end
  endtask

  task automatic reset_check();
    checks++;
    if (out_valid !== 1'b0 || result !== '0) begin
      errors++;
      $display("FAIL R10 reset: actual valid=%b result=%h expected 0", out_valid, result);
    end
  endtask

  initial begin
    int ops;
    ops = 0;
    repeat (3) @(negedge clk);
    reset_check();
    rst_n = 1'b1;
    @(negedge clk);

    // Directed: NaN and denormal patterns stay raw bits (R1)
    enc_ext = 1; vlen = 2'b10; mask_en = 0; bcast = 0; b_is_mem = 0;
    src_a = {8{64'h7FF8_0000_0000_0001}};
    src_b = {8{64'h0000_0000_0000_0003}};
    old_dst = '0;
    run_op();

    for (int e = 0; e < 2; e++)
      for (int v = 0; v < 4; v++)
        for (int c = 0; c < 16; c++)
          for (int m = 0; m < 256; m++) begin
            @(negedge clk);
            enc_ext = e[0]; vlen = v[1:0];
            {mask_en, zero_mode, bcast, b_is_mem} = c[3:0];
            lane_mask = m[7:0];
            src_a = rnd512(); src_b = rnd512(); old_dst = rnd512();
            run_op();
            ops++;
            if (ops % 97 == 0) idle_check();
          end

    // Reset in the middle of activity (R10)
    @(negedge clk);
    src_a = rnd512(); src_b = rnd512(); enc_ext = 1;
    run_op();
    rst_n = 1'b0;
    #1;
    reset_check();
    @(negedge clk);
    reset_check();
    finish_run();
  end
endmodule